// File: doc/BRIEF.md
# DMA Request/Acknowledge Peripheral Port

This block is the peripheral end of a request/acknowledge DMA handshake for one endpoint data buffer. When it is enabled, has words left in its programmed transfer, and the buffer can take part (holding data for a transfer out to the bus, or having room for a transfer in from it), it raises a request line. An external DMA controller answers with an acknowledge. Each word then moves over a shared data bus, and the block drives that bus only while the transfer is in progress.

Two strobe styles are available. In normal mode the read or write strobe, given while acknowledge is held, marks each word. In acknowledge-only mode the acknowledge pulse is itself the data strobe, and the read and write strobes play no part. Two request policies are available. In single-cycle mode the request drops after every word. In burst mode it stays up until the last word of the programmed length. All bus pins are active-low and asynchronous. They pass through a two-stage synchronizer, and a word completes on the trailing edge of the synchronized strobe.

Top module: `dmap_port`

## Requirements
- R1: With `cfg_en`=1, a non-zero remaining count and a ready buffer, `dreq` is high. For `cfg_to_host`=1, ready means `buf_empty`=0. For `cfg_to_host`=0, ready means `buf_full`=0.
- R2: `dreq` is low while `cfg_en`=0, while the remaining count is zero, or while the buffer is not ready.
- R3: With `cfg_burst`=0, `dreq` falls after each completed word and stays low for as long as `dack_n` stays low.
- R4: With `cfg_burst`=1, `dreq` stays high between words and falls only after the last word of the programmed length.
- R5: In normal mode (`cfg_ack_only`=0) with `cfg_to_host`=1, `bus_oe` is high and `bus_dout` carries the buffer head word while `dack_n` and `rd_n` are both low.
- R6: `bus_oe` goes low once `dack_n` has been high for three clocks.
- R7: With `cfg_ack_only`=1, a low pulse on `dack_n` alone completes a word, and `rd_n`/`wr_n` have no effect.
- R8: Each completed strobe gives exactly one `buf_pop` when `cfg_to_host`=1, or one `buf_push` carrying the `bus_din` value held during the strobe when `cfg_to_host`=0.
- R9: A `start` pulse loads `xfer_len` into the remaining count. Each completed word decrements the count, and `done` is high when the count is zero.
- R10: Synchronous reset leaves `dreq`=0, `bus_oe`=0 and `done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables requests |
| cfg_ack_only | input | 1 | 1: acknowledge is the data strobe |
| cfg_burst | input | 1 | 1: burst request policy, 0: single-cycle |
| cfg_to_host | input | 1 | 1: buffer to bus, 0: bus to buffer |
| start | input | 1 | Loads the transfer length |
| xfer_len | input | LEN_W | Words to transfer |
| buf_rd_data | input | DATA_W | Buffer head word |
| buf_empty | input | 1 | Buffer has no data |
| buf_pop | output | 1 | Consume head word |
| buf_full | input | 1 | Buffer has no room |
| buf_push | output | 1 | Write `buf_wr_data` |
| buf_wr_data | output | DATA_W | Word captured from the bus |
| dreq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active-low |
| rd_n | input | 1 | Read strobe, active-low |
| wr_n | input | 1 | Write strobe, active-low |
| bus_din | input | DATA_W | Data bus input |
| bus_dout | output | DATA_W | Data bus output |
| bus_oe | output | 1 | Data bus output enable |
| done | output | 1 | Remaining count is zero |

## Verification
On the last word of a burst, the trailing strobe edge pops or pushes the buffer in the same cycle that the count reaches zero. The request decision must then see both events together. The bench brings this about by ending every burst transfer on its programmed final word. It then checks that `dreq` is low and `done` high, and that the number of pops or pushes equals the length exactly. In single-cycle acknowledge-only mode, the completion also falls in the cycle that releases the hold-off. The bench confirms there that the request comes back for the next word and not before the word completes.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  typedef struct packed {
    logic en;
    logic ack_only;
    logic burst;
    logic to_host;
  } dmap_cfg_t;
endpackage

// File: rtl/dmap_sync.sv
module dmap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dmap_strobe.sv
module dmap_strobe
  import dmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dmap_cfg_t         cfg,
  input  logic              dack,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic              active,
  output logic              fire,
  output logic [DATA_W-1:0] cap
);
  logic act_q;

  // the strobe qualifier depends on mode and direction
  assign active = dack & (cfg.ack_only | (cfg.to_host ? rd : wr));
  assign fire   = act_q & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cap   <= '0;
    end else begin
      act_q <= active;
      if (active) cap <= din;
    end
  end
endmodule

// File: rtl/dmap_count.sv
module dmap_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec,
  output logic             zero,
  output logic             one
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= len;
    else if (dec && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
  assign one  = (cnt == LEN_W'(1));
endmodule

// File: rtl/dmap_port.sv
module dmap_port
  import dmap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_ack_only,
  input  logic              cfg_burst,
  input  logic              cfg_to_host,
  input  logic              start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [DATA_W-1:0] buf_rd_data,
  input  logic              buf_empty,
  output logic              buf_pop,
  input  logic              buf_full,
  output logic              buf_push,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              dreq,
  input  logic              dack_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              done
);
  localparam int SW = DATA_W + 3;

  dmap_cfg_t cfg;
  assign cfg = '{en: cfg_en, ack_only: cfg_ack_only, burst: cfg_burst, to_host: cfg_to_host};

  logic [SW-1:0] pins_s;
  logic dack_s, rd_s, wr_s;
  logic [DATA_W-1:0] din_s;

  dmap_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({dack_n, rd_n, wr_n, bus_din}), .q(pins_s)
  );

  assign dack_s = ~pins_s[SW-1];
  assign rd_s   = ~pins_s[SW-2];
  assign wr_s   = ~pins_s[SW-3];
  assign din_s  = pins_s[DATA_W-1:0];

  logic active, fire;

  dmap_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .cfg(cfg), .dack(dack_s), .rd(rd_s), .wr(wr_s),
    .din(din_s), .active(active), .fire(fire), .cap(buf_wr_data)
  );

  logic cnt_zero, cnt_one;

  dmap_count #(.LEN_W(LEN_W)) u_count (
    .clk(clk), .rst(rst), .load(start), .len(xfer_len), .dec(fire),
    .zero(cnt_zero), .one(cnt_one)
  );

  assign buf_pop  = fire & cfg.to_host;
  assign buf_push = fire & ~cfg.to_host;
  assign done     = cnt_zero;

  // single-cycle hold-off until acknowledge is seen released
  logic hold_q;
  always_ff @(posedge clk) begin
    if (rst)                      hold_q <= 1'b0;
    else if (!cfg.burst && fire)  hold_q <= 1'b1;
    else if (!dack_s)             hold_q <= 1'b0;
  end

  logic buf_ok, last, dreq_d;
  assign buf_ok = cfg.to_host ? ~buf_empty : ~buf_full;
  assign last   = fire & cnt_one;
  assign dreq_d = cfg.en & ~cnt_zero & ~last & buf_ok & ~hold_q
                & ~(~cfg.burst & fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq     <= 1'b0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      dreq     <= dreq_d;
      bus_oe   <= cfg.en & cfg.to_host & dack_s & (cfg.ack_only | rd_s);
      bus_dout <= buf_rd_data;
    end
  end
endmodule

// File: rtl/dmap_port_chk.sv
module dmap_port_chk (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic cfg_burst,
  input logic start,
  input logic dack_n,
  input logic buf_pop,
  input logic buf_push,
  input logic dreq,
  input logic bus_oe,
  input logic done
);
  p_oe_released_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(dack_n, 1) && $past(dack_n, 2) && $past(dack_n, 3)) |-> !bus_oe);

  p_one_action_r8: assert property (@(posedge clk) disable iff (rst)
    !(buf_pop && buf_push));

  p_single_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_burst && (buf_pop || buf_push)) |=> !dreq);

  p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !dreq);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !dreq);
endmodule

bind dmap_port dmap_port_chk u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_burst(cfg_burst), .start(start),
  .dack_n(dack_n), .buf_pop(buf_pop), .buf_push(buf_push), .dreq(dreq),
  .bus_oe(bus_oe), .done(done)
);

// File: tb/dmap_port_tb_top.sv
`timescale 1ns/1ps
module dmap_port_tb_top;
  localparam int DW = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, cfg_en, cfg_ack_only, cfg_burst, cfg_to_host, start;
  logic [LW-1:0] xfer_len;
  logic [DW-1:0] buf_rd_data, buf_wr_data, bus_din, bus_dout;
  logic buf_empty, buf_full, buf_pop, buf_push, dreq, dack_n, rd_n, wr_n, bus_oe, done;

  dmap_port #(.DATA_W(DW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_ack_only(cfg_ack_only),
    .cfg_burst(cfg_burst), .cfg_to_host(cfg_to_host), .start(start),
    .xfer_len(xfer_len), .buf_rd_data(buf_rd_data), .buf_empty(buf_empty),
    .buf_pop(buf_pop), .buf_full(buf_full), .buf_push(buf_push),
    .buf_wr_data(buf_wr_data), .dreq(dreq), .dack_n(dack_n), .rd_n(rd_n),
    .wr_n(wr_n), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .done(done)
  );

  // endpoint buffer model
  int rptr, rfill, wcnt, wcap;
  logic [DW-1:0] wmem [64];

  function automatic logic [DW-1:0] rword(int i);
    return DW'(8'h30 + i * 7);
  endfunction
  function automatic logic [DW-1:0] bword(int i);
    return DW'(8'hA0 + i * 3);
  endfunction

  assign buf_rd_data = rword(rptr);
  assign buf_empty   = (rptr >= rfill);
  assign buf_full    = (wcnt >= wcap);

  always @(posedge clk) begin
    if (buf_pop) rptr <= rptr + 1;
    if (buf_push) begin
      wmem[wcnt[5:0]] <= buf_wr_data;
      wcnt <= wcnt + 1;
    end
  end

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // {ack_only, burst, to_host, len}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'd4},
    {1'b0, 1'b1, 1'b1, 8'd4},
    {1'b1, 1'b0, 1'b0, 8'd3},
    {1'b1, 1'b1, 1'b0, 8'd3},
    {1'b0, 1'b0, 1'b0, 8'd2},
    {1'b1, 1'b1, 1'b1, 8'd3}
  };

  task automatic run_xfer(bit ao, bit bu, bit th, int len);
    int p0;
    cfg_en = 1; cfg_ack_only = ao; cfg_burst = bu; cfg_to_host = th;
    @(negedge clk);
    rptr = 0; rfill = len; wcnt = 0; wcap = 64;
    p0 = 0;
    xfer_len = LW'(len); start = 1;
    @(negedge clk); start = 0;
    wait_n(6);
    chk(dreq == 1, "R1", int'(dreq), 1);
    chk(done == 0, "R9", int'(done), 0);
    for (int w = 0; w < len; w++) begin
      bus_din = bword(w);
      dack_n = 0;
      if (!ao) begin
        if (th) rd_n = 0; else wr_n = 0;
      end
      wait_n(6);
      if (th) begin
        chk(bus_oe == 1, ao ? "R7" : "R5", int'(bus_oe), 1);
        chk(bus_dout == rword(w), ao ? "R7" : "R5", int'(bus_dout), int'(rword(w)));
      end
      if (!ao) begin
        rd_n = 1; wr_n = 1;
        wait_n(6);
        chk(dreq == (bu && w != len-1), bu ? "R4" : "R3", int'(dreq), int'(bu && w != len-1));
        wait_n(6);
        if (!bu) chk(dreq == 0, "R3", int'(dreq), 0);
      end
      dack_n = 1;
      wait_n(6);
      chk(bus_oe == 0, "R6", int'(bus_oe), 0);
      chk(dreq == (w != len-1), bu ? "R4" : "R1", int'(dreq), int'(w != len-1));
    end
    chk(done == 1, "R9", int'(done), 1);
    chk(dreq == 0, "R2", int'(dreq), 0);
    if (th) chk(rptr == len, "R8", rptr, len);
    else begin
      chk(wcnt == len, "R8", wcnt, len);
      for (int w = 0; w < len; w++)
        chk(wmem[w] == bword(w), "R8", int'(wmem[w]), int'(bword(w)));
    end
  endtask

  initial begin
    rst = 1; cfg_en = 0; cfg_ack_only = 0; cfg_burst = 0; cfg_to_host = 1;
    start = 0; xfer_len = 0; dack_n = 1; rd_n = 1; wr_n = 1; bus_din = 0;
    rptr = 0; rfill = 0; wcnt = 0; wcap = 64;
    wait_n(4);
    rst = 0;
    wait_n(2);
    chk(dreq == 0, "R10", int'(dreq), 0);
    chk(bus_oe == 0, "R10", int'(bus_oe), 0);
    chk(done == 1, "R10", int'(done), 1);

    for (int v = 0; v < NV; v++)
      run_xfer(VEC[v][10], VEC[v][9], VEC[v][8], int'(VEC[v][7:0]));

    // disabled: no request (R2)
    cfg_en = 0; cfg_to_host = 1; rptr = 0; rfill = 8;
    xfer_len = 4; start = 1; @(negedge clk); start = 0;
    wait_n(6);
    chk(dreq == 0, "R2", int'(dreq), 0);
    chk(done == 0, "R9", int'(done), 0);

    // empty buffer on read (R2)
    cfg_en = 1; rfill = 0;
    wait_n(6);
    chk(dreq == 0, "R2", int'(dreq), 0);
    rfill = 8;
    wait_n(6);
    chk(dreq == 1, "R1", int'(dreq), 1);

    // full buffer on write (R2)
    cfg_to_host = 0; wcnt = 0; wcap = 0;
    wait_n(6);
    chk(dreq == 0, "R2", int'(dreq), 0);
    wcap = 64;
    wait_n(6);
    chk(dreq == 1, "R1", int'(dreq), 1);

    // acknowledge-only: read strobe alone is ignored (R7)
    cfg_to_host = 1; cfg_ack_only = 1; rptr = 0;
    rd_n = 0; wait_n(6); rd_n = 1; wait_n(6);
    wr_n = 0; wait_n(6); wr_n = 1; wait_n(6);
    chk(rptr == 0, "R7", rptr, 0);
    chk(bus_oe == 0, "R7", int'(bus_oe), 0);
    chk(dreq == 1, "R7", int'(dreq), 1);
    chk(done == 0, "R7", int'(done), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule